// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Set-Less-Than

This block is a purely combinational 32-bit integer ALU made from a chain of identical one-bit slices. Every slice can complement its A operand and its B operand, computes the AND, the OR and the full-adder sum of the conditioned bits, and picks one of those or a "less" input with a two-bit operation field. The slices ripple their carries from bit 0 upward. The carry into bit 0 is the B-negate control bit, so complementing B and adding one gives two's-complement subtraction without any extra logic.

The slice at the most significant end also produces the sign of the sum and an overflow indication. That sign bit is routed back to the less input of bit 0. All other slices take a constant zero on that input, so set-less-than yields 0 or 1 in bit 0. NOR needs no gate of its own: it is the AND path with both operands complemented. A zero flag over the whole result supports branch-on-equal after a subtract. A datapath feeds operands and a 4-bit control word and reads the result and the flags in the same cycle.

Top module: `alu_ripple32`

## Requirements
- R1: The control word is ctrl_i = {invert_a (bit 3), negate_b (bit 2), op (bits 1:0)}. AND is 4'b0000 and gives result_o = a_i & b_i.
- R2: Control 4'b0001 (OR) gives result_o = a_i | b_i.
- R3: Control 4'b0010 (ADD) gives result_o = (a_i + b_i) mod 2^32.
- R4: Control 4'b0110 (SUB) gives result_o = (a_i - b_i) mod 2^32.
- R5: Control 4'b0111 (SLT) gives result_o[31:1] = 0. Bit 0 equals bit 31 of the 32-bit difference a_i - b_i, with no correction for overflow.
- R6: Control 4'b1100 (NOR) gives result_o = ~(a_i | b_i).
- R7: Any control value other than the six listed above gives result_o = 0.
- R8: zero_o is 1 exactly when every bit of result_o is 0.
- R9: carry_o is bit 32 of A' + B' + negate_b for every control value. Here A' is a_i, complemented when invert_a is set, and B' is b_i, complemented when negate_b is set.
- R10: overflow_o is 1 exactly when A' and B' (as defined in R9) have equal sign bits and bit 31 of A' + B' + negate_b differs from them. This holds for every control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | {invert_a, negate_b, op[1:0]} |
| result_o | output | 32 | Selected result |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of the adder chain |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The hardest case to reach is the set-less-than path when the subtraction overflows. There, bit 0 shows the wrapped sign, and it is reached only with operands of opposite sign and large magnitude. Random 32-bit operands seldom sit near those limits, so the stimulus pairs the most negative value, the most positive value, -1 and 0 directly with every control code. The random phase also draws operands of equal value, so that the zero flag asserts after a subtract.

// File: rtl/alu_pkg.sv
// Package: control word layout and encodings shared by the ALU modules.
// Assumes: the control word is {invert_a, negate_b, op[1:0]}.
package alu_pkg;

    typedef struct packed {
        logic       inv_a;
        logic       neg_b;
        logic [1:0] op;
    } alu_ctrl_t;

    localparam logic [1:0] OP_AND  = 2'b00;
    localparam logic [1:0] OP_OR   = 2'b01;
    localparam logic [1:0] OP_SUM  = 2'b10;
    localparam logic [1:0] OP_LESS = 2'b11;

    localparam logic [3:0] CTRL_AND = 4'b0000;
    localparam logic [3:0] CTRL_OR  = 4'b0001;
    localparam logic [3:0] CTRL_ADD = 4'b0010;
    localparam logic [3:0] CTRL_SUB = 4'b0110;
    localparam logic [3:0] CTRL_SLT = 4'b0111;
    localparam logic [3:0] CTRL_NOR = 4'b1100;

endpackage

// File: rtl/alu_ctrl_decode.sv
// Module: splits the 4-bit control word into slice controls and flags
// whether the word is one of the six defined operations.
// Assumes: any undefined word must force the result to zero downstream.
module alu_ctrl_decode
    import alu_pkg::*;
(
    input  logic [3:0] ctrl_i,
    output alu_ctrl_t  fields_o,
    output logic       valid_o
);

    // Purpose: field split and legal-code match.
    always_comb begin
        fields_o = alu_ctrl_t'(ctrl_i);
        unique case (ctrl_i)
            CTRL_AND, CTRL_OR, CTRL_ADD,
            CTRL_SUB, CTRL_SLT, CTRL_NOR: valid_o = 1'b1;
            default:                      valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module: one ALU bit. It conditionally complements each operand bit, forms
// AND, OR and the full-adder sum, and selects an output by op.
// Assumes: less_i is tied low everywhere except bit 0.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       neg_b_i,
    input  logic [1:0] op_i,
    input  logic       cin_i,
    input  logic       less_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic a_c;
    logic b_c;

    // Purpose: operand conditioning, adder and output multiplexer.
    always_comb begin
        a_c    = inv_a_i ? ~a_i : a_i;
        b_c    = neg_b_i ? ~b_i : b_i;
        sum_o  = a_c ^ b_c ^ cin_i;
        cout_o = (b_c & cin_i) | (a_c & cin_i) | (a_c & b_c);
        unique case (op_i)
            OP_AND:  res_o = a_c & b_c;
            OP_OR:   res_o = a_c | b_c;
            OP_SUM:  res_o = sum_o;
            default: res_o = less_i;
        endcase
    end

endmodule

// File: rtl/alu_msb_slice.sv
// Module: the most significant ALU bit. It is a normal slice that also
// exports its sum bit (the sign, used for set-less-than) and a signed
// overflow flag taken from the carries around it.
// Assumes: it is placed at bit WIDTH-1 and its less input is tied low.
module alu_msb_slice (
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       neg_b_i,
    input  logic [1:0] op_i,
    input  logic       cin_i,
    output logic       res_o,
    output logic       set_o,
    output logic       ovf_o,
    output logic       cout_o
);

    alu_bit_slice u_core (
        .a_i     (a_i),
        .b_i     (b_i),
        .inv_a_i (inv_a_i),
        .neg_b_i (neg_b_i),
        .op_i    (op_i),
        .cin_i   (cin_i),
        .less_i  (1'b0),
        .res_o   (res_o),
        .sum_o   (set_o),
        .cout_o  (cout_o)
    );

    // Purpose: signed overflow when carry-in and carry-out of the top bit differ.
    always_comb ovf_o = cin_i ^ cout_o;

endmodule

// File: rtl/alu_zero_detect.sv
// Module: wide NOR over the result for branch-equal decisions.
// Assumes: WIDTH >= 1.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             zero_o
);

    // Purpose: report when no bit is set.
    always_comb zero_o = ~(|data_i);

endmodule

// File: rtl/alu_ripple32.sv
// Module: top of the ripple-carry ALU. It chains WIDTH one-bit slices, feeds
// negate_b as the carry into bit 0, loops the top slice's sign back to bit 0
// for set-less-than, and clears the result for undefined control words.
// Assumes: purely combinational, no clock or reset; WIDTH >= 2.
module alu_ripple32
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       ctrl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o,
    output logic             carry_o
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        fields;
    logic             ctrl_ok;
    logic [WIDTH-1:0] raw_res;
    logic             msb_set;

    alu_ctrl_decode u_dec (
        .ctrl_i   (ctrl_i),
        .fields_o (fields),
        .valid_o  (ctrl_ok)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin_w;
        logic cout_w;
        logic res_w;

        if (i == 0) begin : g_lsb_cin
            assign cin_w = fields.neg_b;
        end else begin : g_chain_cin
            assign cin_w = g_bit[i-1].cout_w;
        end

        if (i == MSB) begin : g_top
            alu_msb_slice u_slice (
                .a_i     (a_i[i]),
                .b_i     (b_i[i]),
                .inv_a_i (fields.inv_a),
                .neg_b_i (fields.neg_b),
                .op_i    (fields.op),
                .cin_i   (cin_w),
                .res_o   (res_w),
                .set_o   (msb_set),
                .ovf_o   (overflow_o),
                .cout_o  (cout_w)
            );
            assign carry_o = cout_w;
        end else begin : g_low
            logic sum_unused;
            alu_bit_slice u_slice (
                .a_i     (a_i[i]),
                .b_i     (b_i[i]),
                .inv_a_i (fields.inv_a),
                .neg_b_i (fields.neg_b),
                .op_i    (fields.op),
                .cin_i   (cin_w),
                .less_i  ((i == 0) ? msb_set : 1'b0),
                .res_o   (res_w),
                .sum_o   (sum_unused),
                .cout_o  (cout_w)
            );
        end

        assign raw_res[i] = res_w;
    end

    // Purpose: suppress the result for undefined control words.
    always_comb result_o = ctrl_ok ? raw_res : '0;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .data_i (result_o),
        .zero_o (zero_o)
    );

endmodule

// File: rtl/alu_ripple32_checker.sv
// Module: assertion checker bound to alu_ripple32. The block has no clock,
// so every check is an immediate assertion evaluated on settled values.
// Assumes: WIDTH matches the bound instance.
module alu_ripple32_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       ctrl_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             overflow_o,
    input logic             carry_o
);

    logic legal;

    // Purpose: recompute legality independently of the decoder.
    always_comb legal = (ctrl_i == CTRL_AND) || (ctrl_i == CTRL_OR)  ||
                        (ctrl_i == CTRL_ADD) || (ctrl_i == CTRL_SUB) ||
                        (ctrl_i == CTRL_SLT) || (ctrl_i == CTRL_NOR);

    // Purpose: output relations checked on every input change.
    always_comb begin
        if (!$isunknown({a_i, b_i, ctrl_i})) begin
            assert_illegal_zero_R7: assert (legal || result_o == '0);
            assert_zero_flag_R8: assert (zero_o == (result_o == '0));
            assert_slt_upper_clear_R5: assert (ctrl_i != CTRL_SLT || result_o[WIDTH-1:1] == '0);
            assert_nor_value_R6: assert (ctrl_i != CTRL_NOR || result_o == ~(a_i | b_i));
            assert_equal_sub_zero_R4: assert (ctrl_i != CTRL_SUB || a_i != b_i || zero_o);
            assert_add_mixed_sign_R10: assert (ctrl_i != CTRL_ADD ||
                                               a_i[WIDTH-1] == b_i[WIDTH-1] || !overflow_o);
            assert_sub_carry_R9: assert (ctrl_i != CTRL_SUB || carry_o == (a_i >= b_i));
        end
    end

endmodule

bind alu_ripple32 alu_ripple32_checker #(.WIDTH(WIDTH)) u_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .ctrl_i     (ctrl_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
);

// File: tb/alu_ripple32_tb.sv
// Bench: random and directed vectors against reference functions.
module alu_ripple32_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic [3:0]   ctrl;
    logic [W-1:0] res;
    logic         zero, ovf, cout;
    int           n_checks = 0;
    int           n_fail = 0;
    int           cycles = 0;
    bit           done = 1'b0;

    alu_ripple32 #(.WIDTH(W)) u_dut (
        .a_i(a), .b_i(b), .ctrl_i(ctrl),
        .result_o(res), .zero_o(zero), .overflow_o(ovf), .carry_o(cout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Purpose: requirement tag for the result of each control code.
    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Purpose: expected result from the requirement text.
    function automatic logic [W-1:0] exp_res(input logic [W-1:0] x, y, input logic [3:0] c);
        logic [W-1:0] d;
        d = x - y;
        case (c)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return x + y;
            4'b0110: return d;
            4'b0111: return {{(W-1){1'b0}}, d[W-1]};
            4'b1100: return ~(x | y);
            default: return '0;
        endcase
    endfunction

    // Purpose: expected {overflow, carry} of the conditioned adder (R9, R10).
    function automatic logic [1:0] exp_flags(input logic [W-1:0] x, y, input logic [3:0] c);
        logic [W-1:0] xa, yb;
        logic [W:0]   s;
        xa = c[3] ? ~x : x;
        yb = c[2] ? ~y : y;
        s  = {1'b0, xa} + {1'b0, yb} + {{W{1'b0}}, c[2]};
        return {(xa[W-1] == yb[W-1]) && (s[W-1] != xa[W-1]), s[W]};
    endfunction

    task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h ctrl=%b actual=%h expected=%h", req, a, b, ctrl, act, expv);
        end
    endtask

    // Purpose: apply one vector at a falling edge, check at the rising edge.
    task automatic run_vec(input logic [W-1:0] x, y, input logic [3:0] c);
        logic [W-1:0] er;
        logic [1:0]   ef;
        @(negedge clk);
        a = x; b = y; ctrl = c;
        er = exp_res(x, y, c);
        ef = exp_flags(x, y, c);
        @(posedge clk);
        cmp(tag_of(c), res, er);
        cmp("R8", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
        cmp("R9", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, ef[0]});
        cmp("R10", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, ef[1]});
    endtask

    // Purpose: end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0]   codes [6];
        logic [W-1:0] corner [6];
        int unsigned  seed;
        codes  = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
        corner = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h5555_AAAA};
        seed = 32'h1234_5678;
        void'($urandom(seed));
        a = '0; b = '0; ctrl = 4'b0000;
        repeat (3) @(posedge clk);
        // Reset-time state: zero operands with AND give a zero result (R1, R8).
        cmp("R1", res, '0);
        cmp("R8", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
        rst_n = 1'b1;

        // Directed: every corner pair under every defined code.
        foreach (corner[i]) foreach (corner[j]) foreach (codes[k])
            run_vec(corner[i], corner[j], codes[k]);
        // Directed: SLT overflow case (R5) and equal-operand SUB (R4, R8).
        run_vec(32'h8000_0000, 32'h0000_0001, 4'b0111);
        run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
        run_vec(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);
        // Undefined codes give zero (R7).
        for (int c = 0; c < 16; c++) run_vec(32'hF0F0_1234, 32'h0FF0_8765, c[3:0]);

        // Random phase with some equal operands and some undefined codes.
        for (int n = 0; n < 1500; n++) begin
            logic [W-1:0] x, y;
            logic [3:0]   c;
            x = $urandom();
            y = ($urandom_range(0, 7) == 0) ? x : $urandom();
            c = ($urandom_range(0, 9) == 0) ? 4'($urandom()) : codes[$urandom_range(0, 5)];
            run_vec(x, y, c);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule